// File: doc/BRIEF.md
# Machine Check Error Router

This block sits beside a processor core's exception logic and decides, on every clock, what to do with the hardware errors reported to it. There are five error sources. The first is an external machine-check request pin. Two come from cache parity checking, one for the instruction cache and one for the data cache. One is an address parity error seen while snooping. The last is a data parity error on a read transfer. Each source has a mask taken from a control register. The cache pair shares a single mask, and the two bus parity sources each count only in their own transfer context.

The machine-check enable bit of the machine state register does not mask anything. It selects how an unmasked error is handled. When the bit is 1, the block issues a recoverable interrupt request. When it is 0, the block enters a fatal checkstop that holds until reset. A cause register records which sources fired, so the handler can read them. Software clears cause bits with a write-one-to-clear strobe.

Top module: `mcheck_router`

## Requirements
- R1: When `enExtMc` is 0, `extMcIn` has no effect: no interrupt, no checkstop and no cause bit.
- R2: An unmasked error sampled at a clock edge with `msrMcEnable`=1 and no checkstop drives `mcIrq` high for the single cycle after that edge.
- R3: An unmasked error sampled with `msrMcEnable`=0 sets `checkstop` after that edge, and `mcIrq` stays low.
- R4: `enCacheParity` gates both `icacheParErr` and `dcacheParErr`; when it is 0, neither has any effect.
- R5: `snoopAddrParErr` counts only when `snoopActive` and `enAddrParity` are both 1.
- R6: `readDataParErr` counts only when `readXfer` and `enDataParity` are both 1.
- R7: `checkstop` stays at 1 until reset, and `mcIrq` stays low while it is set.
- R8: Several unmasked sources firing in the same cycle produce one single-cycle `mcIrq` pulse.
- R9: `cause` sets a bit for each unmasked source that fired, whether the error was routed to an interrupt or to a checkstop. Bit 0 is external, bit 1 instruction cache, bit 2 data cache, bit 3 snoop address parity and bit 4 read data parity. Bits hold until cleared.
- R10: A 1 in `causeClr` clears the matching `cause` bit at the next edge. A source firing at that same edge sets the bit anyway.
- R11: After reset, `mcIrq`, `checkstop` and `cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extMcIn | input | 1 | External machine-check request |
| icacheParErr | input | 1 | Instruction cache parity error |
| dcacheParErr | input | 1 | Data cache parity error |
| snoopAddrParErr | input | 1 | Address parity error on the bus |
| snoopActive | input | 1 | A snoop operation is in progress this cycle |
| readDataParErr | input | 1 | Data parity error on the bus |
| readXfer | input | 1 | The current transfer is a read |
| enExtMc | input | 1 | Mask for the external request |
| enCacheParity | input | 1 | Shared mask for both cache parity sources |
| enAddrParity | input | 1 | Mask for snoop address parity |
| enDataParity | input | 1 | Mask for read data parity |
| msrMcEnable | input | 1 | 1: route to interrupt, 0: route to checkstop |
| causeClr | input | 5 | Write-one-to-clear strobe for cause bits |
| mcIrq | output | 1 | Single-cycle machine check interrupt request |
| checkstop | output | 1 | Sticky checkstop flag |
| cause | output | 5 | Recorded error sources |

## Verification
The assertions assume that every input is a synchronous level that is valid at each rising edge. They also assume that `msrMcEnable` is a clean 0 or 1, so that a single error can never be routed to both an interrupt and a checkstop. The bench changes inputs only on falling edges and holds them steady through the following rising edge. It releases reset between falling edges, so every sampled value is well defined. The stimulus toggles the transfer-context inputs `snoopActive` and `readXfer` on their own and with their masks. This exercises the context gating separately from the masking.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int SRC_N = 5;
  localparam int SRC_EXT = 0;
  localparam int SRC_ICACHE = 1;
  localparam int SRC_DCACHE = 2;
  localparam int SRC_ADDRPAR = 3;
  localparam int SRC_DATAPAR = 4;

  typedef logic [SRC_N-1:0] srcVec_t;

  typedef struct packed {
    logic capture;
    logic raiseIrq;
  } mcStrobe_t;
endpackage

// File: rtl/mcRouteData.sv
module mcRouteData
  import mcr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  srcVec_t   rawVec,
  input  srcVec_t   enVec,
  input  srcVec_t   ctxVec,
  input  srcVec_t   causeClr,
  input  mcStrobe_t strobe,
  output srcVec_t   hitVec,
  output srcVec_t   causeQ,
  output logic      irqQ
);
  // Each source counts only if unmasked and inside its transfer context.
  for (genvar i = 0; i < SRC_N; i++) begin : g_qual
    assign hitVec[i] = rawVec[i] & enVec[i] & ctxVec[i];
  end

  srcVec_t setMask;
  assign setMask = strobe.capture ? hitVec : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      causeQ <= (causeQ & ~causeClr) | setMask;
      irqQ   <= strobe.raiseIrq;
    end
  end
endmodule

// File: rtl/mcRouteCtrl.sv
module mcRouteCtrl
  import mcr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  srcVec_t   hitVec,
  input  logic      msrMcEnable,
  output mcStrobe_t strobe,
  output logic      stopQ
);
  logic anyHit;
  logic enterStop;

  assign anyHit    = |hitVec;
  assign enterStop = anyHit & ~msrMcEnable;

  always_comb begin
    strobe.capture  = anyHit;
    strobe.raiseIrq = anyHit & msrMcEnable & ~stopQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopQ <= 1'b0;
    else if (enterStop) stopQ <= 1'b1;
  end
endmodule

// File: rtl/mcheck_router.sv
module mcheck_router
  import mcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             extMcIn,
  input  logic             icacheParErr,
  input  logic             dcacheParErr,
  input  logic             snoopAddrParErr,
  input  logic             snoopActive,
  input  logic             readDataParErr,
  input  logic             readXfer,
  input  logic             enExtMc,
  input  logic             enCacheParity,
  input  logic             enAddrParity,
  input  logic             enDataParity,
  input  logic             msrMcEnable,
  input  logic [SRC_N-1:0] causeClr,
  output logic             mcIrq,
  output logic             checkstop,
  output logic [SRC_N-1:0] cause
);
  srcVec_t   rawVec, enVec, ctxVec, hitVec;
  mcStrobe_t strobe;

  always_comb begin
    rawVec = '0;
    enVec  = '0;
    ctxVec = '1;
    rawVec[SRC_EXT]     = extMcIn;
    rawVec[SRC_ICACHE]  = icacheParErr;
    rawVec[SRC_DCACHE]  = dcacheParErr;
    rawVec[SRC_ADDRPAR] = snoopAddrParErr;
    rawVec[SRC_DATAPAR] = readDataParErr;
    enVec[SRC_EXT]      = enExtMc;
    enVec[SRC_ICACHE]   = enCacheParity;
    enVec[SRC_DCACHE]   = enCacheParity;
    enVec[SRC_ADDRPAR]  = enAddrParity;
    enVec[SRC_DATAPAR]  = enDataParity;
    ctxVec[SRC_ADDRPAR] = snoopActive;
    ctxVec[SRC_DATAPAR] = readXfer;
  end

  mcRouteData u_data (
    .clk(clk), .rstN(rstN), .rawVec(rawVec), .enVec(enVec), .ctxVec(ctxVec),
    .causeClr(causeClr), .strobe(strobe), .hitVec(hitVec), .causeQ(cause),
    .irqQ(mcIrq)
  );

  mcRouteCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .hitVec(hitVec), .msrMcEnable(msrMcEnable),
    .strobe(strobe), .stopQ(checkstop)
  );
endmodule

// File: rtl/mcRouteChecker.sv
module mcRouteChecker (
  input logic       clk,
  input logic       rstN,
  input logic       extMcIn,
  input logic       icacheParErr,
  input logic       dcacheParErr,
  input logic       snoopAddrParErr,
  input logic       readDataParErr,
  input logic       msrMcEnable,
  input logic       mcIrq,
  input logic       checkstop,
  input logic [4:0] cause
);
  assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |=> checkstop);

  assert_no_irq_in_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(mcIrq && checkstop));

  assert_me_low_no_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    !msrMcEnable |=> !mcIrq);

  assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    mcIrq |-> (cause != 5'd0));

  assert_quiet_inputs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!extMcIn && !icacheParErr && !dcacheParErr && !snoopAddrParErr && !readDataParErr)
      |=> (!mcIrq && $stable(checkstop)));
endmodule

bind mcheck_router mcRouteChecker u_chk (
  .clk(clk), .rstN(rstN), .extMcIn(extMcIn), .icacheParErr(icacheParErr),
  .dcacheParErr(dcacheParErr), .snoopAddrParErr(snoopAddrParErr),
  .readDataParErr(readDataParErr), .msrMcEnable(msrMcEnable), .mcIrq(mcIrq),
  .checkstop(checkstop), .cause(cause)
);

// File: tb/test_mcheck_router.sv
`timescale 1ns/1ps
module test_mcheck_router;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extMcIn = 0, icacheParErr = 0, dcacheParErr = 0, snoopAddrParErr = 0;
  logic snoopActive = 0, readDataParErr = 0, readXfer = 0;
  logic enExtMc = 0, enCacheParity = 0, enAddrParity = 0, enDataParity = 0;
  logic msrMcEnable = 0;
  logic [4:0] causeClr = '0;
  logic mcIrq, checkstop;
  logic [4:0] cause;

  int checks = 0;
  int fails = 0;
  bit expIrq = 0;
  bit expStop = 0;
  bit [4:0] expCause = '0;

  always #4 clk = ~clk;

  mcheck_router i_mcheck_router (
    .clk(clk), .rstN(rstN), .extMcIn(extMcIn), .icacheParErr(icacheParErr),
    .dcacheParErr(dcacheParErr), .snoopAddrParErr(snoopAddrParErr),
    .snoopActive(snoopActive), .readDataParErr(readDataParErr), .readXfer(readXfer),
    .enExtMc(enExtMc), .enCacheParity(enCacheParity), .enAddrParity(enAddrParity),
    .enDataParity(enDataParity), .msrMcEnable(msrMcEnable), .causeClr(causeClr),
    .mcIrq(mcIrq), .checkstop(checkstop), .cause(cause)
  );

  task automatic check(string tag);
    checks += 3;
    if (mcIrq !== expIrq) begin
      fails++; $display("FAIL %s mcIrq got %0b exp %0b", tag, mcIrq, expIrq);
    end
    if (checkstop !== expStop) begin
      fails++; $display("FAIL %s checkstop got %0b exp %0b", tag, checkstop, expStop);
    end
    if (cause !== expCause) begin
      fails++; $display("FAIL %s cause got %05b exp %05b", tag, cause, expCause);
    end
  endtask

  // Behavioural model: predict from the inputs in place, advance one edge, compare.
  task automatic tick(string tag);
    bit [4:0] fired;
    bit nIrq, nStop;
    fired = '0;
    if (extMcIn && enExtMc) fired[0] = 1;
    if (icacheParErr && enCacheParity) fired[1] = 1;
    if (dcacheParErr && enCacheParity) fired[2] = 1;
    if (snoopAddrParErr && snoopActive && enAddrParity) fired[3] = 1;
    if (readDataParErr && readXfer && enDataParity) fired[4] = 1;
    nIrq = 0;
    nStop = expStop;
    if (fired != 0) begin
      if (!msrMcEnable) nStop = 1;
      else if (!expStop) nIrq = 1;
    end
    @(posedge clk);
    expIrq = nIrq;
    expStop = nStop;
    expCause = (expCause & ~causeClr) | fired;
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    extMcIn = 0; icacheParErr = 0; dcacheParErr = 0; snoopAddrParErr = 0;
    readDataParErr = 0; snoopActive = 0; readXfer = 0; causeClr = '0;
  endtask

  task automatic doReset();
    rstN = 0;
    @(posedge clk); @(negedge clk);
    expIrq = 0; expStop = 0; expCause = '0;
    rstN = 1;
    check("R11 reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1: external request masked, both routings
    msrMcEnable = 1; extMcIn = 1; tick("R1 masked me1");
    msrMcEnable = 0; tick("R1 masked me0");
    // R2 interrupt path
    quiet(); msrMcEnable = 1; enExtMc = 1; extMcIn = 1; tick("R2 irq");
    quiet(); tick("R2 pulse ends");
    causeClr = 5'b00001; tick("R10 clear");
    // R4 shared cache mask
    quiet(); icacheParErr = 1; dcacheParErr = 1; tick("R4 masked");
    enCacheParity = 1; dcacheParErr = 0; tick("R4 icache");
    icacheParErr = 0; dcacheParErr = 1; tick("R4 dcache");
    causeClr = 5'b11111; tick("R10 set wins");
    quiet(); causeClr = 5'b11111; tick("R10 clear all");
    // R5 snoop context
    quiet(); snoopAddrParErr = 1; enAddrParity = 1; tick("R5 no snoop");
    enAddrParity = 0; snoopActive = 1; tick("R5 masked");
    enAddrParity = 1; tick("R5 fire");
    // R6 read context
    quiet(); readDataParErr = 1; enDataParity = 1; tick("R6 no read");
    enDataParity = 0; readXfer = 1; tick("R6 masked");
    enDataParity = 1; tick("R6 fire");
    quiet(); causeClr = 5'b11111; tick("R10 clear");
    // R8 all sources at once
    quiet(); extMcIn = 1; icacheParErr = 1; dcacheParErr = 1; snoopAddrParErr = 1;
    snoopActive = 1; readDataParErr = 1; readXfer = 1; tick("R8 multi");
    quiet(); tick("R8 single pulse");
    causeClr = 5'b11111; tick("R9 clear");
    // R3 checkstop path, cause still recorded
    quiet(); msrMcEnable = 0; dcacheParErr = 1; tick("R3 checkstop");
    // R7 sticky and suppressing
    quiet(); msrMcEnable = 1; extMcIn = 1; tick("R7 suppress");
    quiet();
    for (int k = 0; k < 4; k++) tick("R7 sticky");
    doReset();
    msrMcEnable = 1; extMcIn = 1; tick("R2 after reset");
    quiet(); tick("R2 idle");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule